// File: doc/BRIEF.md
# Strided Bank Address Generator

This block walks a strided vector through an interleaved memory. A single start pulse carries a byte base address, a signed stride counted in 8-byte words, and an element count. From these the block issues one element address per cycle at most. Each request is steered to the bank that the word address selects, and the block remembers how long each bank stays occupied. When an element would land on a bank that is still busy, issue waits. Elements are never reordered. So the achieved rate depends on how the stride interacts with the bank count. A stride of zero, or any stride that is a multiple of the bank count, keeps hitting one bank.

The memory is modelled as a fixed-latency pipe. Every request comes back a set number of cycles after it was issued, carrying its element index and its address. One cycle after the last element returns, a completion pulse follows. A new stream can only be started while the block is idle. The defaults are 16 banks, a 4-cycle bank occupancy and a 12-cycle return latency. The parameters also allow other arrangements, such as 8 banks with a 6-cycle latency.

Top module: `stride_bank_agu`

## Requirements
- R1: After reset, and throughout reset, `req_valid`, `rsp_valid` and `done` are low and `busy` is low.
- R2: Element i of a stream is requested at byte address (base with bits [2:0] cleared) + i × stride × 8, modulo 2^AW. The stride is a two's-complement word count. Elements are requested in index order, and `req_idx` equals i.
- R3: The target bank is the word address modulo NBANK, which is `req_addr` bits [3 +: log2(NBANK)], and `req_bank` reports it. A base of byte 136 with stride 1 starts at bank 1 (word 17).
- R4: At most one request is issued per cycle. A bank that received a request in cycle t receives no further request before cycle t + BUSY.
- R5: Element 0 may issue in the first cycle after the start is sampled. Element i issues in the earliest cycle that is after element i−1 and in which its bank is free. Issue never skips ahead.
- R6: An element count above MAXVL (64) is treated as MAXVL.
- R7: An element count of zero produces no requests. `done` is high in the first cycle after the start is sampled, and `busy` stays low.
- R8: Every request returns on `rsp_valid` exactly LAT cycles after the cycle in which it was issued. The return carries the same `rsp_idx` and `rsp_addr`, and returns come in issue order.
- R9: `done` is a one-cycle pulse in the cycle after the last element's return.
- R10: `busy` is high from the first cycle after an accepted non-empty start up to and including the cycle of the last return. A `start` pulse while `busy` is high is ignored.
- R11: A zero stride repeatedly targets one bank and issues exactly one element every BUSY cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a stream (sampled while idle) |
| base_addr | input | AW | Byte base address |
| stride | input | SW | Signed stride in 8-byte words |
| vlen | input | VLW | Requested element count |
| busy | output | 1 | Stream in progress |
| req_valid | output | 1 | Request issued this cycle |
| req_addr | output | AW | Byte address of the request |
| req_bank | output | log2(NBANK) | Bank targeted by the request |
| req_idx | output | log2(MAXVL) | Element index of the request |
| rsp_valid | output | 1 | Return this cycle |
| rsp_idx | output | log2(MAXVL) | Element index of the return |
| rsp_addr | output | AW | Address of the returned element |
| done | output | 1 | Pulse one cycle after the last return |

## Verification
A bank timer that is loaded wrongly, or that clears too early, appears at the ports within BUSY cycles. It shows as a request to a bank whose previous request is less than BUSY cycles old, or as an idle cycle where a free bank could have taken the element. Either way the request cycle no longer matches a greedy schedule computed independently. A wrong address step or index count is visible on the very next request. A fault in the return pipe shows LAT cycles later as a return in the wrong cycle or with the wrong index. A wrong remaining count shifts the `done` pulse or the number of returns before it.

// File: rtl/sba_pkg.sv
package sba_pkg;
  // bytes per word expressed as a shift
  localparam int BYTE_OFS_W = 3;

  typedef enum logic {SB_IDLE, SB_RUN} sb_state_e;

  // clamp the requested count to the register length
  function automatic int eff_count(input int req, input int cap);
    return (req > cap) ? cap : req;
  endfunction
endpackage

// File: rtl/sba_stream.sv
module sba_stream #(
  parameter int AW    = 32,
  parameter int SW    = 16,
  parameter int VLW   = 7,
  parameter int MAXVL = 64,
  localparam int WW   = AW - sba_pkg::BYTE_OFS_W,
  localparam int IW   = $clog2(MAXVL),
  localparam int CW   = $clog2(MAXVL + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_acc,
  input  logic [AW-1:0]  base_i,
  input  logic [SW-1:0]  stride_i,
  input  logic [VLW-1:0] vlen_i,
  input  logic           bank_free_i,
  output logic           run_o,
  output logic [WW-1:0]  word_o,
  output logic [IW-1:0]  idx_o,
  output logic           issue_o,
  output logic           last_o
);
  import sba_pkg::*;

  sb_state_e     st_q;
  logic [WW-1:0] word_q;
  logic [SW-1:0] stride_q;
  logic [IW-1:0] idx_q;
  logic [CW-1:0] left_q;
  logic [CW-1:0] len_eff;

  always_comb begin
    len_eff = CW'(eff_count(int'(vlen_i), MAXVL));
  end

  assign run_o   = (st_q == SB_RUN);
  assign issue_o = run_o && bank_free_i;
  assign last_o  = (left_q == CW'(1));
  assign word_o  = word_q;
  assign idx_o   = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= SB_IDLE;
      word_q   <= '0;
      stride_q <= '0;
      idx_q    <= '0;
      left_q   <= '0;
    end else if (start_acc) begin
      word_q   <= WW'(base_i >> BYTE_OFS_W);
      stride_q <= stride_i;
      idx_q    <= '0;
      left_q   <= len_eff;
      st_q     <= (len_eff == '0) ? SB_IDLE : SB_RUN;
    end else if (issue_o) begin
      word_q <= word_q + WW'($signed(stride_q));
      idx_q  <= idx_q + IW'(1);
      left_q <= left_q - CW'(1);
      if (last_o) st_q <= SB_IDLE;
    end
  end
endmodule

// File: rtl/sba_bank_timers.sv
module sba_bank_timers #(
  parameter int NBANK = 16,
  parameter int BUSY  = 4,
  localparam int BBW  = $clog2(NBANK),
  localparam int TW   = $clog2(BUSY + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [BBW-1:0] sel_i,
  input  logic           hit_i,
  output logic           free_o
);
  logic [TW-1:0] tmr [NBANK];

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rst_n)                          tmr[g] <= '0;
      else if (hit_i && sel_i == BBW'(g))  tmr[g] <= TW'(BUSY - 1);
      else if (tmr[g] != '0)               tmr[g] <= tmr[g] - TW'(1);
    end
  end

  assign free_o = (tmr[sel_i] == '0);
endmodule

// File: rtl/sba_return_pipe.sv
module sba_return_pipe #(
  parameter int LAT = 12,
  parameter int AW  = 32,
  parameter int IW  = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [IW-1:0] idx_i,
  input  logic [AW-1:0] addr_i,
  input  logic          last_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o,
  output logic [AW-1:0] addr_o,
  output logic          last_o,
  output logic          inflight_o
);
  logic [LAT-1:0] v_q;
  logic [IW-1:0]  i_q [LAT];
  logic [AW-1:0]  a_q [LAT];
  logic [LAT-1:0] l_q;

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) v_q[0] <= 1'b0;
        else        v_q[0] <= push_i;
        i_q[0] <= idx_i;
        a_q[0] <= addr_i;
        l_q[0] <= last_i;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) v_q[g] <= 1'b0;
        else        v_q[g] <= v_q[g-1];
        i_q[g] <= i_q[g-1];
        a_q[g] <= a_q[g-1];
        l_q[g] <= l_q[g-1];
      end
    end
  end

  assign vld_o      = v_q[LAT-1];
  assign idx_o      = i_q[LAT-1];
  assign addr_o     = a_q[LAT-1];
  assign last_o     = l_q[LAT-1] & v_q[LAT-1];
  assign inflight_o = |v_q;
endmodule

// File: rtl/stride_bank_agu.sv
module stride_bank_agu #(
  parameter int AW    = 32,
  parameter int SW    = 16,
  parameter int VLW   = 7,
  parameter int MAXVL = 64,
  parameter int NBANK = 16,
  parameter int BUSY  = 4,
  parameter int LAT   = 12,
  localparam int BBW  = $clog2(NBANK),
  localparam int IW   = $clog2(MAXVL),
  localparam int WW   = AW - sba_pkg::BYTE_OFS_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  base_addr,
  input  logic [SW-1:0]  stride,
  input  logic [VLW-1:0] vlen,
  output logic           busy,
  output logic           req_valid,
  output logic [AW-1:0]  req_addr,
  output logic [BBW-1:0] req_bank,
  output logic [IW-1:0]  req_idx,
  output logic           rsp_valid,
  output logic [IW-1:0]  rsp_idx,
  output logic [AW-1:0]  rsp_addr,
  output logic           done
);
  import sba_pkg::*;

  // named internal events
  logic          start_acc;
  logic          run_w;
  logic          issue_w;
  logic          last_elem_w;
  logic          bank_free_w;
  logic          inflight_w;
  logic          rsp_last_w;
  logic [WW-1:0] word_w;
  logic          done_q;

  assign start_acc = start && !busy;

  sba_stream #(
    .AW(AW), .SW(SW), .VLW(VLW), .MAXVL(MAXVL)
  ) u_stream (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc),
    .base_i(base_addr), .stride_i(stride), .vlen_i(vlen),
    .bank_free_i(bank_free_w), .run_o(run_w), .word_o(word_w),
    .idx_o(req_idx), .issue_o(issue_w), .last_o(last_elem_w)
  );

  assign req_bank  = word_w[BBW-1:0];
  assign req_addr  = {word_w, {BYTE_OFS_W{1'b0}}};
  assign req_valid = issue_w;

  sba_bank_timers #(
    .NBANK(NBANK), .BUSY(BUSY)
  ) u_timers (
    .clk(clk), .rst_n(rst_n), .sel_i(req_bank),
    .hit_i(issue_w), .free_o(bank_free_w)
  );

  sba_return_pipe #(
    .LAT(LAT), .AW(AW), .IW(IW)
  ) u_ret (
    .clk(clk), .rst_n(rst_n), .push_i(issue_w), .idx_i(req_idx),
    .addr_i(req_addr), .last_i(last_elem_w), .vld_o(rsp_valid),
    .idx_o(rsp_idx), .addr_o(rsp_addr), .last_o(rsp_last_w),
    .inflight_o(inflight_w)
  );

  assign busy = run_w | inflight_w;

  always_ff @(posedge clk) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= rsp_last_w | (start_acc && vlen == '0);
  end

  assign done = done_q;
endmodule

// File: rtl/sba_chk.sv
module sba_chk #(
  parameter int AW    = 32,
  parameter int SW    = 16,
  parameter int VLW   = 7,
  parameter int MAXVL = 64,
  parameter int NBANK = 16,
  parameter int BUSY  = 4,
  localparam int BBW  = $clog2(NBANK),
  localparam int IW   = $clog2(MAXVL)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic [AW-1:0]  base_addr,
  input logic [SW-1:0]  stride,
  input logic [VLW-1:0] vlen,
  input logic           busy,
  input logic           req_valid,
  input logic [AW-1:0]  req_addr,
  input logic [BBW-1:0] req_bank,
  input logic [IW-1:0]  req_idx,
  input logic           rsp_valid,
  input logic [IW-1:0]  rsp_idx,
  input logic           done
);
  logic [AW-1:0]  base_q;
  logic [SW-1:0]  stride_q;
  logic [VLW-1:0] vlen_q;
  logic [AW-1:0]  prev_addr;
  logic [IW-1:0]  prev_idx;
  int             rsp_cnt;
  int             exp_cnt;
  int             age [NBANK];

  always_comb exp_cnt = sba_pkg::eff_count(int'(vlen_q), MAXVL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0; stride_q <= '0; vlen_q <= '0;
      prev_addr <= '0; prev_idx <= '0; rsp_cnt <= 0;
      for (int b = 0; b < NBANK; b++) age[b] <= BUSY;
    end else begin
      if (start && !busy) begin
        base_q <= base_addr; stride_q <= stride; vlen_q <= vlen;
        rsp_cnt <= 0;
      end else if (rsp_valid) begin
        rsp_cnt <= rsp_cnt + 1;
      end
      if (req_valid) begin
        prev_addr <= req_addr;
        prev_idx  <= req_idx;
      end
      for (int b = 0; b < NBANK; b++) begin
        if (req_valid && int'(req_addr[3 +: BBW]) == b) age[b] <= 1;
        else if (age[b] < BUSY)                        age[b] <= age[b] + 1;
      end
    end
  end

  // R4
  bank_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> age[req_addr[3 +: BBW]] >= BUSY);

  // R3
  bank_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_bank == req_addr[3 +: BBW]);

  // R2
  first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_idx == '0) |-> req_addr == (base_q & ~AW'(7)));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_idx != '0) |->
      (req_addr == prev_addr + (AW'($signed(stride_q)) << 3)) && (req_idx == prev_idx + IW'(1)));

  // R8
  rsp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> int'(rsp_idx) == rsp_cnt);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> rsp_cnt == exp_cnt);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid && !rsp_valid);
endmodule

bind stride_bank_agu sba_chk #(
  .AW(AW), .SW(SW), .VLW(VLW), .MAXVL(MAXVL), .NBANK(NBANK), .BUSY(BUSY)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
  .stride(stride), .vlen(vlen), .busy(busy), .req_valid(req_valid),
  .req_addr(req_addr), .req_bank(req_bank), .req_idx(req_idx),
  .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .done(done)
);

// File: tb/sim_stride_bank_agu.sv
module sim_stride_bank_agu;
  localparam int CLK_PER = 10;
  localparam int NBANK   = 16;
  localparam int BUSY    = 4;
  localparam int LAT     = 12;
  localparam int MAXVL   = 64;
  localparam int NVEC    = 11;

  // {base[31:0], stride[15:0], vlen[6:0], poke}
  localparam logic [55:0] VEC [NVEC] = '{
    {32'h0000_0000, 16'h0001, 7'd8,   1'b0},  // unit stride, no stalls
    {32'h0000_0088, 16'h0001, 7'd20,  1'b0},  // byte 136 -> bank 1 (R3)
    {32'h0000_0040, 16'h0000, 7'd5,   1'b0},  // zero stride (R11)
    {32'h0000_0008, 16'h0010, 7'd4,   1'b0},  // stride = bank count
    {32'h0000_0000, 16'h0008, 7'd6,   1'b0},  // two banks alternate
    {32'h0000_0320, 16'hFFFD, 7'd10,  1'b1},  // negative stride, start poked (R10)
    {32'h0000_0005, 16'h0002, 7'd64,  1'b0},  // max length, unaligned base
    {32'h0000_0010, 16'h0001, 7'd0,   1'b0},  // empty (R7)
    {32'h0000_0100, 16'h0001, 7'd100, 1'b0},  // clamp (R6)
    {32'hFFFF_FFF0, 16'h0001, 7'd4,   1'b0},  // address wrap
    {32'h0000_0000, 16'h0004, 7'd12,  1'b1}   // four-bank rotation, poked
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic [15:0] stride = '0;
  logic [6:0]  vlen = '0;
  logic        busy, req_valid, rsp_valid, done;
  logic [31:0] req_addr, rsp_addr;
  logic [3:0]  req_bank;
  logic [5:0]  req_idx, rsp_idx;

  int nchk = 0;
  int nfail = 0;

  always #(CLK_PER/2) clk = ~clk;

  stride_bank_agu u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .stride(stride), .vlen(vlen), .busy(busy), .req_valid(req_valid),
    .req_addr(req_addr), .req_bank(req_bank), .req_idx(req_idx),
    .rsp_valid(rsp_valid), .rsp_idx(rsp_idx), .rsp_addr(rsp_addr),
    .done(done)
  );

  task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic run_stream(input logic [31:0] b, input logic [15:0] s, input logic [6:0] n_in, input bit poke);
    int          n, ri, pi, prev, end_c, sw;
    int          t [MAXVL];
    int          last [NBANK];
    logic [31:0] ea [MAXVL];
    n  = (int'(n_in) > MAXVL) ? MAXVL : int'(n_in);
    sw = int'($signed(s));
    for (int k = 0; k < NBANK; k++) last[k] = -1000;
    prev = -1;
    for (int i = 0; i < n; i++) begin
      int bk, ti;
      ea[i] = (b & 32'hFFFF_FFF8) + 32'(i * sw * 8);
      bk    = int'(ea[i][6:3]);
      ti    = (prev + 1 > last[bk] + BUSY) ? prev + 1 : last[bk] + BUSY;
      t[i] = ti; last[bk] = ti; prev = ti;
    end
    end_c = (n > 0) ? t[n-1] + LAT + 1 : 0;
    base_addr = b; stride = s; vlen = n_in; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ri = 0; pi = 0;
    for (int c = 0; c <= end_c + 1; c++) begin
      bit er, ep;
      er = (ri < n) && (t[ri] == c);
      ep = (pi < n) && (t[pi] + LAT == c);
      chk(req_valid == er, "R4/R5 req_valid timing", 64'(req_valid), 64'(er));
      if (er) begin
        chk(req_addr == ea[ri], "R2 req_addr", 64'(req_addr), 64'(ea[ri]));
        chk(int'(req_idx) == ri, "R2 req_idx", 64'(req_idx), 64'(ri));
        chk(req_bank == ea[ri][6:3], "R3 req_bank", 64'(req_bank), 64'(ea[ri][6:3]));
        ri++;
      end
      chk(rsp_valid == ep, "R8 rsp_valid timing", 64'(rsp_valid), 64'(ep));
      if (ep) begin
        chk(int'(rsp_idx) == pi, "R8 rsp_idx", 64'(rsp_idx), 64'(pi));
        chk(rsp_addr == ea[pi], "R8 rsp_addr", 64'(rsp_addr), 64'(ea[pi]));
        pi++;
      end
      chk(done == (c == end_c), "R9/R7 done", 64'(done), 64'(c == end_c));
      chk(busy == (n > 0 && c < end_c), "R10 busy", 64'(busy), 64'(n > 0 && c < end_c));
      // R10: a start while busy must leave the stream untouched
      if (poke && c == 1) begin
        base_addr = 32'h0000_7770; stride = 16'h0005; vlen = 7'd3; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    chk(ri == n && pi == n, "R6 element count", 64'(pi), 64'(n));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!req_valid && !rsp_valid && !done && !busy, "R1 reset outputs",
        64'({req_valid, rsp_valid, done, busy}), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!req_valid && !rsp_valid && !done && !busy, "R1 idle after reset",
        64'({req_valid, rsp_valid, done, busy}), 64'(0));

    for (int v = 0; v < NVEC; v++) begin
      run_stream(VEC[v][55:24], VEC[v][23:8], VEC[v][7:1], VEC[v][0]);
      @(negedge clk);
    end

    // R1: reset in the middle of a stream clears everything
    base_addr = 32'h0; stride = 16'h0; vlen = 7'd20; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!req_valid && !rsp_valid && !done && !busy, "R1 mid-stream reset",
        64'({req_valid, rsp_valid, done, busy}), 64'(0));
    rst_n = 1'b1;
    for (int c = 0; c < LAT + 2; c++) begin
      @(negedge clk);
      chk(!rsp_valid && !req_valid, "R1 no stale returns",
          64'({rsp_valid, req_valid}), 64'(0));
    end
    // R11: fresh zero-stride stream after reset
    run_stream(32'h0000_0018, 16'h0000, 7'd7, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule